// File: doc/BRIEF.md
# Word Data Background Sequencer

This block supplies the data words that a memory self-test writes across a word-wide array. These words are chosen so that any two bit positions of one word are driven to every combination of values. The word width `W` is a power of two. From it the block derives `log2(W)+1` base patterns. Base 0 is all zeros. Each later base splits the word into alternating runs of zeros and ones, and each run is half the length of the one in the previous base. Every base is issued once as is and once complemented, so the full set holds `2*(log2(W)+1)` backgrounds. For example, a 128-bit word gets 16 backgrounds.

A test controller walks the set with a single-cycle advance strobe. The order is a base in true form, then its complement, then the next base. A flag marks the final background, so the controller can tell when a full pass is done. The controller can also jump straight to any background by giving a base number and a polarity. It can return to the first background at any time. The block does not touch memory and does not compare read data. It only produces the pattern words and their sequencing.

Top module: `bg_gen`

## Requirements
- R1: After synchronous reset, `pattern` is all zeros, `base_idx` is 0, `inverted` is 0 and `last` is 0.
- R2: A `start` pulse returns the block to base 0 in true form (all-zeros `pattern`) on the next clock edge. It takes priority over `load` and `step`.
- R3: A `step` pulse with no `start` or valid `load` moves from a base in true form to the same base complemented. From a complemented base that is not the final one, it moves to the next base number in true form.
- R4: In true form, base 0 is all zeros. For k ≥ 1, bit i of base k equals bit (log2(W) − k) of the binary number i. For W=16 the true forms of bases 1 to 4 are 0xFF00, 0xF0F0, 0xCCCC and 0xAAAA.
- R5: When `inverted` is 1, `pattern` is the bitwise complement of the true form of the current base.
- R6: `last` is 1 exactly when the current background is the highest base, log2(W), in complemented form.
- R7: A `step` while `last` is 1 wraps to base 0 in true form.
- R8: A `load` with `load_base` below log2(W)+1 moves to that base with polarity `load_inv` on the next edge. It takes priority over `step`.
- R9: A `load` whose `load_base` is log2(W)+1 or more is ignored. If no `step` comes with it, the outputs hold their values.
- R10: `bg_total` always equals 2*(log2(W)+1); for W=16 it is 10.
- R11: Across one full pass of the sequence, every pair of bit positions takes all four value pairs 00, 01, 10 and 11.
- R12: With no `start`, `load` or `step`, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Return to base 0, true form |
| step | input | 1 | Advance to the next background |
| load | input | 1 | Jump to the background given by `load_base` and `load_inv` |
| load_base | input | $clog2(log2(W)+1) | Base number for a jump |
| load_inv | input | 1 | Polarity for a jump, 1 = complemented |
| pattern | output | W | Current background word, registered |
| base_idx | output | $clog2(log2(W)+1) | Current base number |
| inverted | output | 1 | Current polarity, 1 = complemented |
| last | output | 1 | Final background of the pass |
| bg_total | output | $clog2(2*(log2(W)+1)+1) | Number of backgrounds in one pass |

## Verification
The checker looks at every cycle. It checks the step order, including the wrap after the final background, and the priority of `start`. It checks that an out-of-range jump and an idle cycle leave the outputs unchanged. It checks that `last` agrees with the base number and polarity, and that bit 0 of the word tracks the polarity. The exact bit content of each base word, the correct result of a valid jump, and the all-pairs coverage over a whole pass can only be shown by the bench scenarios. The bench compares each word against patterns it builds from the bit rule, and it tests every bit pair over a recorded pass.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_START = 2'd1,
    SRC_LOAD  = 2'd2,
    SRC_STEP  = 2'd3
  } bg_src_e;
endpackage

// File: rtl/bg_arbiter.sv
module bg_arbiter
  import bg_pkg::*;
#(
  parameter int NUM_BASE = 5,
  parameter int BASEW    = 3
) (
  input  logic             start,
  input  logic             load,
  input  logic [BASEW-1:0] load_base,
  input  logic             step,
  output bg_src_e          src
);
  logic load_ok;

  always_comb begin
    load_ok = int'(load_base) < NUM_BASE;
    if (start)               src = SRC_START;
    else if (load && load_ok) src = SRC_LOAD;
    else if (step)           src = SRC_STEP;
    else                     src = SRC_HOLD;
  end
endmodule

// File: rtl/bg_index.sv
module bg_index
  import bg_pkg::*;
#(
  parameter int NUM_BASE = 5,
  parameter int BASEW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  bg_src_e          src,
  input  logic [BASEW-1:0] load_base,
  input  logic             load_inv,
  output logic [BASEW-1:0] base_q,
  output logic             inv_q,
  output logic [BASEW-1:0] base_nxt,
  output logic             inv_nxt
);
  localparam logic [BASEW-1:0] TOP_BASE = BASEW'(NUM_BASE - 1);

  always_comb begin
    base_nxt = base_q;
    inv_nxt  = inv_q;
    unique case (src)
      SRC_START: begin
        base_nxt = '0;
        inv_nxt  = 1'b0;
      end
      SRC_LOAD: begin
        base_nxt = load_base;
        inv_nxt  = load_inv;
      end
      SRC_STEP: begin
        if (!inv_q) begin
          inv_nxt = 1'b1;
        end else if (base_q == TOP_BASE) begin
          base_nxt = '0;
          inv_nxt  = 1'b0;
        end else begin
          base_nxt = base_q + 1'b1;
          inv_nxt  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      inv_q  <= 1'b0;
    end else begin
      base_q <= base_nxt;
      inv_q  <= inv_nxt;
    end
  end
endmodule

// File: rtl/bg_pattern.sv
module bg_pattern #(
  parameter int W        = 16,
  parameter int LOG2W    = 4,
  parameter int NUM_BASE = 5,
  parameter int BASEW    = 3
) (
  input  logic [BASEW-1:0] base,
  input  logic             inv,
  output logic [W-1:0]     word
);
  logic [W-1:0] tbl [NUM_BASE];

  for (genvar k = 0; k < NUM_BASE; k++) begin : g_base
    for (genvar i = 0; i < W; i++) begin : g_bit
      localparam logic BITV = (k == 0) ? 1'b0 : (((i >> (LOG2W - k)) % 2) == 1);
      assign tbl[k][i] = BITV;
    end
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < NUM_BASE; k++) begin
      if (int'(base) == k) word = tbl[k];
    end
    word = word ^ {W{inv}};
  end
endmodule

// File: rtl/bg_gen.sv
module bg_gen
  import bg_pkg::*;
#(
  parameter int W        = 16,
  parameter int LOG2W    = $clog2(W),
  parameter int NUM_BASE = LOG2W + 1,
  parameter int NUM_BG   = 2 * NUM_BASE,
  parameter int BASEW    = $clog2(NUM_BASE),
  parameter int CNTW     = $clog2(NUM_BG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic             load,
  input  logic [BASEW-1:0] load_base,
  input  logic             load_inv,
  output logic [W-1:0]     pattern,
  output logic [BASEW-1:0] base_idx,
  output logic             inverted,
  output logic             last,
  output logic [CNTW-1:0]  bg_total
);
  localparam logic [BASEW-1:0] TOP_BASE = BASEW'(NUM_BASE - 1);

  bg_src_e          src;
  logic [BASEW-1:0] base_nxt;
  logic             inv_nxt;
  logic [W-1:0]     word_nxt;

  bg_arbiter #(.NUM_BASE(NUM_BASE), .BASEW(BASEW)) u_arb (
    .start(start), .load(load), .load_base(load_base), .step(step), .src(src)
  );

  bg_index #(.NUM_BASE(NUM_BASE), .BASEW(BASEW)) u_idx (
    .clk(clk), .rst(rst), .src(src), .load_base(load_base), .load_inv(load_inv),
    .base_q(base_idx), .inv_q(inverted), .base_nxt(base_nxt), .inv_nxt(inv_nxt)
  );

  bg_pattern #(.W(W), .LOG2W(LOG2W), .NUM_BASE(NUM_BASE), .BASEW(BASEW)) u_pat (
    .base(base_nxt), .inv(inv_nxt), .word(word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pattern <= '0;
      last    <= 1'b0;
    end else begin
      pattern <= word_nxt;
      last    <= inv_nxt && (base_nxt == TOP_BASE);
    end
  end

  assign bg_total = CNTW'(NUM_BG);
endmodule

// File: rtl/bg_gen_chk.sv
module bg_gen_chk #(
  parameter int W        = 16,
  parameter int NUM_BASE = 5,
  parameter int BASEW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             step,
  input logic             load,
  input logic [BASEW-1:0] load_base,
  input logic [W-1:0]     pattern,
  input logic [BASEW-1:0] base_idx,
  input logic             inverted,
  input logic             last
);
  localparam logic [BASEW-1:0] TOP_BASE = BASEW'(NUM_BASE - 1);
  logic load_bad;
  assign load_bad = int'(load_base) >= NUM_BASE;

  assert_start_home_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (pattern == '0 && base_idx == '0 && !inverted));

  assert_step_to_inv_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !(load && !load_bad) && !inverted)
      |=> (inverted && base_idx == $past(base_idx)));

  assert_step_to_next_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !(load && !load_bad) && inverted && !last)
      |=> (!inverted && base_idx == $past(base_idx) + 1'b1));

  assert_polarity_bit0_R5: assert property (@(posedge clk) disable iff (rst)
    pattern[0] == inverted);

  assert_last_flag_R6: assert property (@(posedge clk) disable iff (rst)
    last == (inverted && base_idx == TOP_BASE));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !(load && !load_bad) && last)
      |=> (base_idx == '0 && !inverted && pattern == '0));

  assert_bad_load_R9: assert property (@(posedge clk) disable iff (rst)
    (load && load_bad && !start && !step)
      |=> ($stable(pattern) && $stable(base_idx) && $stable(inverted)));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!start && !load && !step)
      |=> ($stable(pattern) && $stable(base_idx) && $stable(inverted) && $stable(last)));
endmodule

bind bg_gen bg_gen_chk #(.W(W), .NUM_BASE(NUM_BASE), .BASEW(BASEW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .step(step), .load(load),
  .load_base(load_base), .pattern(pattern), .base_idx(base_idx),
  .inverted(inverted), .last(last)
);

// File: tb/tb_bg_gen.sv
module tb_bg_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W        = 16;
  localparam int LOG2W    = 4;
  localparam int NUM_BASE = LOG2W + 1;
  localparam int NUM_BG   = 2 * NUM_BASE;
  localparam int BASEW    = 3;
  localparam int CNTW     = 4;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, step = 1'b0, load = 1'b0, load_inv = 1'b0;
  logic [BASEW-1:0] load_base = '0;
  logic [W-1:0]     pattern;
  logic [BASEW-1:0] base_idx;
  logic             inverted, last;
  logic [CNTW-1:0]  bg_total;

  always #(CLK_PERIOD/2) clk = ~clk;

  bg_gen #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .step(step), .load(load),
    .load_base(load_base), .load_inv(load_inv), .pattern(pattern),
    .base_idx(base_idx), .inverted(inverted), .last(last), .bg_total(bg_total)
  );

  typedef struct {
    logic [W-1:0] pat;
    int           base;
    logic         inv;
    logic         lst;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int m_base = 0;
  logic m_inv = 1'b0;
  logic [W-1:0] rec [NUM_BG];

  function automatic logic [W-1:0] true_form(int k);
    logic [W-1:0] v;
    v = '0;
    for (int i = 0; i < W; i++)
      if (k != 0) v[i] = ((i >> (LOG2W - k)) & 1) == 1;
    return v;
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] expv);
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  // driver: apply one cycle of strobes, update model, push expected outputs
  task automatic drive(string tag, logic s, logic l, int lb, logic li, logic st);
    @(negedge clk);
    start = s; load = l; load_base = BASEW'(lb); load_inv = li; step = st;
    if (s) begin
      m_base = 0; m_inv = 1'b0;
    end else if (l && lb < NUM_BASE) begin
      m_base = lb; m_inv = li;
    end else if (st) begin
      if (!m_inv) m_inv = 1'b1;
      else if (m_base == NUM_BASE - 1) begin m_base = 0; m_inv = 1'b0; end
      else begin m_base = m_base + 1; m_inv = 1'b0; end
    end
    @(posedge clk);
    #1;
    start = 1'b0; load = 1'b0; step = 1'b0; load_inv = 1'b0; load_base = '0;
    exp_q.push_back('{pat: true_form(m_base) ^ {W{m_inv}}, base: m_base, inv: m_inv,
                      lst: (m_inv && m_base == NUM_BASE - 1), tag: tag});
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.tag, " pattern"}, pattern, e.pat);
      check({e.tag, " base"}, W'(base_idx), W'(e.base));
      check({e.tag, " inverted"}, W'(inverted), W'(e.inv));
      check({e.tag, " last"}, W'(last), W'(e.lst));
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state, R10 total count
    check("R1 pattern", pattern, '0);
    check("R1 base", W'(base_idx), '0);
    check("R1 inverted", W'(inverted), '0);
    check("R1 last", W'(last), '0);
    check("R10 total", W'(bg_total), W'(NUM_BG));

    drive("R12 idle", 0, 0, 0, 0, 0);
    // R3/R4/R5/R6 full pass with recording
    drive("R2 start", 1, 0, 0, 0, 0);
    @(negedge clk); rec[0] = pattern;
    for (int n = 1; n < NUM_BG; n++) begin
      drive("R3 R4 R5 R6 sweep", 0, 0, 0, 0, 1);
      @(negedge clk); rec[n] = pattern;
    end
    drive("R7 wrap", 0, 0, 0, 0, 1);
    drive("R8 load", 0, 1, 3, 1, 0);
    drive("R8 load over step", 0, 1, 2, 0, 1);
    drive("R3 step after load", 0, 0, 0, 0, 1);
    drive("R9 bad load 5", 0, 1, 5, 1, 0);
    drive("R9 bad load 7", 0, 1, 7, 0, 0);
    drive("R8 load final", 0, 1, 4, 1, 0);
    drive("R12 idle", 0, 0, 0, 0, 0);
    drive("R2 start over load step", 1, 1, 3, 1, 1);
    drive("R12 idle", 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);

    // R11 every bit pair sees 00,01,10,11 across the recorded pass
    for (int a = 0; a < W; a++) begin
      for (int b = a + 1; b < W; b++) begin
        logic [3:0] seen;
        seen = '0;
        for (int n = 0; n < NUM_BG; n++) seen[{rec[n][a], rec[n][b]}] = 1'b1;
        check("R11 pair combos", W'(seen), W'(4'hF));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule